// File: doc/BRIEF.md
# Public-Key Accelerator Host Front End

This block sits between a host bus and a public-key arithmetic engine. The host loads four 2048-bit operand memories: A, B, an exponent/scalar memory E, and a modulus memory N. The host then picks a routine and starts it by writing to a trigger register. The engine reads operands and writes its results into memory B through a separate port. The block raises a one-cycle start pulse for the engine, and it gathers errors from two sources: host reads of the write-only memory E, and engine-reported faults.

Each error source has a mask bit. A masked error leaves no trace. An unmasked error does three things: it latches a status bit, raises the error interrupt and holds the engine halted. These stay in force until the host clears the status through the clear register. Routine codes with the top bit set select elliptic-curve mode. In that mode the engine addresses A and B as four equal segments, while E is always addressed linearly.

The host bus uses 32-bit words and word addresses. Address bit 8 selects register space (1) or memory space (0). In memory space, bits 7:6 pick the memory (0=A, 1=B, 2=E, 3=N) and bits 5:0 pick the word. Word 0 of each memory carries its most significant 32 bits.

Top module: `pkha_top`

## Requirements
- R1: A host write stores a word in memory A, B or N, and a host read of it returns the word one cycle later with `host_rvalid` high. Word offset 0 is the most significant word of the operand.
- R2: A host read of memory E returns zero data with `host_rvalid` high. The same read raises the address error, which is status bit 0.
- R3: While an error's mask bit is set (register offset 2, bit 0 address error, bit 1 engine error), that error changes neither the status (offset 1), `err_irq` nor `eng_halt`.
- R4: An unmasked error sets its status bit, `err_irq` and `eng_halt` at the first clock edge after the error.
- R5: `err_irq` equals the OR of the status bits and stays high across idle cycles until the status is cleared.
- R6: Any host write to register offset 4 gives a one-cycle `eng_start` pulse on the following cycle, whatever the data. `eng_routine` carries the code written at register offset 0, and offset 0 reads back that code.
- R7: While `eng_halt` is high, writes to register offset 4 give no `eng_start`.
- R8: A write to register offset 3 with bit 0 set clears all status bits, `err_irq` and `eng_halt`. A write with bit 0 clear does nothing.
- R9: An `eng_err` pulse is the engine error, status bit 1. It passes through the same mask logic as the address error.
- R10: The engine read port returns data one cycle after `eng_rd_en`. When the routine's top bit is set, A and B are read at word `seg*16 + (word mod 16)`; otherwise, and always for E, they are read at `word`.
- R11: The engine write port writes only memory B, using the same segment mapping, and the host can read the result back.
- R12: After reset the status, mask and routine read zero, and `err_irq`, `eng_halt` and `eng_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | 9 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rvalid | output | 1 | Read data valid, one cycle after a read |
| host_rdata | output | 32 | Read data |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_routine | output | 5 | Routine code; top bit selects elliptic-curve mode |
| eng_halt | output | 1 | Engine must stop while high |
| eng_err | input | 1 | One-cycle engine fault pulse |
| eng_rd_en | input | 1 | Engine operand read strobe |
| eng_rd_mem | input | 2 | Memory to read (0=A,1=B,2=E,3=N) |
| eng_rd_seg | input | 2 | Segment used in elliptic-curve mode |
| eng_rd_word | input | 6 | Word index |
| eng_rd_data | output | 32 | Operand data, one cycle after the read |
| eng_wr_en | input | 1 | Result write strobe into memory B |
| eng_wr_seg | input | 2 | Result segment in elliptic-curve mode |
| eng_wr_word | input | 6 | Result word index |
| eng_wr_data | input | 32 | Result data |
| err_irq | output | 1 | Error interrupt |

## Verification
The bench reads E with the mask both open and closed. A design that let the memory through would leak exponent data, and one that ignored the mask would raise the interrupt or halt. It tries to start the engine while halted, and it writes the clear register with bit 0 low. Either mistake shows up as a spurious start pulse or as a status that disappears. It drives segmented engine reads and writes with elliptic-curve and linear routine codes, including E under an elliptic-curve code. A mapping error there returns words from the wrong offset.

// File: rtl/pkha_pkg.sv
package pkha_pkg;
  localparam int NUM_MEMS  = 4;
  localparam int MEM_IDX_W = 2;
  localparam logic [1:0] MEM_A = 2'd0;
  localparam logic [1:0] MEM_B = 2'd1;
  localparam logic [1:0] MEM_E = 2'd2;
  localparam logic [1:0] MEM_N = 2'd3;

  localparam int REG_IDX_W = 3;
  localparam logic [2:0] REG_FUNC   = 3'd0;
  localparam logic [2:0] REG_STATUS = 3'd1;
  localparam logic [2:0] REG_MASK   = 3'd2;
  localparam logic [2:0] REG_CLEAR  = 3'd3;
  localparam logic [2:0] REG_GO     = 3'd4;

  localparam int ERR_W    = 2;
  localparam int ERR_ADDR = 0;
  localparam int ERR_ENG  = 1;

  localparam int SEG_SEL_W = 2;
endpackage

// File: rtl/pkha_decode.sv
module pkha_decode
  import pkha_pkg::*;
#(
  parameter int WORD_AW = 6,
  parameter int ADDR_W  = WORD_AW + 3
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 mem_hit,
  output logic [MEM_IDX_W-1:0] mem_idx,
  output logic [WORD_AW-1:0]   word,
  output logic                 reg_hit,
  output logic [REG_IDX_W-1:0] reg_idx
);
  // top bit splits register space from memory space
  assign reg_hit = addr[ADDR_W-1];
  assign mem_hit = ~addr[ADDR_W-1];
  assign mem_idx = addr[WORD_AW +: MEM_IDX_W];
  assign word    = addr[WORD_AW-1:0];
  assign reg_idx = addr[REG_IDX_W-1:0];
endmodule

// File: rtl/pkha_opmem.sv
module pkha_opmem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter bit ENG_WR = 1'b0,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              h_we,
  input  logic              h_re,
  input  logic [AW-1:0]     h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              e_re,
  input  logic              e_we,
  input  logic [AW-1:0]     e_addr,
  input  logic [DATA_W-1:0] e_wdata,
  output logic [DATA_W-1:0] e_rdata
);
  logic [DATA_W-1:0] ram [DEPTH];
  logic              we_eng;

  assign we_eng = ENG_WR && e_we;

  // single write process: engine result has priority over host
  always_ff @(posedge clk) begin
    if (we_eng)    ram[e_addr] <= e_wdata;
    else if (h_we) ram[h_addr] <= h_wdata;
  end

  always_ff @(posedge clk) begin
    if (h_re) h_rdata <= ram[h_addr];
    if (e_re) e_rdata <= ram[e_addr];
  end
endmodule

// File: rtl/pkha_ctrl.sv
module pkha_ctrl
  import pkha_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ROUTINE_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic                 reg_hit,
  input  logic [REG_IDX_W-1:0] reg_idx,
  input  logic [ROUTINE_W-1:0] wdata,
  input  logic                 e_read_req,
  input  logic                 eng_err,
  output logic [ROUTINE_W-1:0] routine,
  output logic                 start,
  output logic                 halt,
  output logic                 irq,
  output logic [DATA_W-1:0]    reg_rdata
);
  logic [ERR_W-1:0] mask_q, status_q, status_n, new_err;
  logic             reg_wr, reg_rd, clr, go;

  assign reg_wr = wr_en && reg_hit;
  assign reg_rd = rd_en && reg_hit;
  assign clr    = reg_wr && (reg_idx == REG_CLEAR) && wdata[0];
  assign go     = reg_wr && (reg_idx == REG_GO);

  always_comb begin
    new_err           = '0;
    new_err[ERR_ADDR] = e_read_req && !mask_q[ERR_ADDR];
    new_err[ERR_ENG]  = eng_err && !mask_q[ERR_ENG];
    status_n          = (clr ? '0 : status_q) | new_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      routine  <= '0;
      mask_q   <= '0;
      status_q <= '0;
      irq      <= 1'b0;
      halt     <= 1'b0;
      start    <= 1'b0;
    end else begin
      if (reg_wr && reg_idx == REG_FUNC) routine <= wdata;
      if (reg_wr && reg_idx == REG_MASK) mask_q  <= wdata[ERR_W-1:0];
      status_q <= status_n;
      irq      <= |status_n;
      halt     <= |status_n;
      start    <= go && !halt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_idx)
        REG_FUNC:   reg_rdata <= DATA_W'(routine);
        REG_STATUS: reg_rdata <= DATA_W'(status_q);
        REG_MASK:   reg_rdata <= DATA_W'(mask_q);
        default:    reg_rdata <= '0;
      endcase
    end
  end

  assert_masked_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (e_read_req && mask_q[ERR_ADDR] && !clr) |=> $stable(status_q[ERR_ADDR]));
  assert_unmasked_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (e_read_req && !mask_q[ERR_ADDR]) |=> (status_q[ERR_ADDR] && halt && irq));
  assert_irq_tracks_R5: assert property (@(posedge clk) disable iff (rst)
    irq == (|status_q));
  assert_go_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (go && !halt) |=> start);
  assert_go_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (go && halt) |=> !start);
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr && !e_read_req && !eng_err) |=> (status_q == '0 && !irq));
  assert_eng_masked_R9: assert property (@(posedge clk) disable iff (rst)
    (eng_err && mask_q[ERR_ENG] && !clr) |=> $stable(status_q[ERR_ENG]));
endmodule

// File: rtl/pkha_top.sv
module pkha_top
  import pkha_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64,
  parameter int ROUTINE_W = 5,
  localparam int WORD_AW  = $clog2(MEM_WORDS),
  localparam int SEG_AW   = WORD_AW - SEG_SEL_W,
  localparam int ADDR_W   = WORD_AW + 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_wr_en,
  input  logic                 host_rd_en,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic [DATA_W-1:0]    host_wdata,
  output logic                 host_rvalid,
  output logic [DATA_W-1:0]    host_rdata,
  output logic                 eng_start,
  output logic [ROUTINE_W-1:0] eng_routine,
  output logic                 eng_halt,
  input  logic                 eng_err,
  input  logic                 eng_rd_en,
  input  logic [MEM_IDX_W-1:0] eng_rd_mem,
  input  logic [SEG_SEL_W-1:0] eng_rd_seg,
  input  logic [WORD_AW-1:0]   eng_rd_word,
  output logic [DATA_W-1:0]    eng_rd_data,
  input  logic                 eng_wr_en,
  input  logic [SEG_SEL_W-1:0] eng_wr_seg,
  input  logic [WORD_AW-1:0]   eng_wr_word,
  input  logic [DATA_W-1:0]    eng_wr_data,
  output logic                 err_irq
);
  logic                 mem_hit, reg_hit, e_read_req, ec_mode;
  logic [MEM_IDX_W-1:0] mem_idx, hsel_q, esel_q;
  logic [WORD_AW-1:0]   hword, erd_addr, ewr_addr;
  logic [REG_IDX_W-1:0] reg_idx;
  logic [DATA_W-1:0]    reg_rdata;
  logic                 src_mem_q, src_reg_q;
  logic [DATA_W-1:0]    hrd   [NUM_MEMS];
  logic [DATA_W-1:0]    erd   [NUM_MEMS];

  function automatic logic [WORD_AW-1:0] seg_map(
    input logic [MEM_IDX_W-1:0] mem, input logic [SEG_SEL_W-1:0] seg,
    input logic [WORD_AW-1:0] w, input logic ec);
    if (ec && mem != MEM_E) return {seg, w[SEG_AW-1:0]};
    return w;
  endfunction

  pkha_decode #(.WORD_AW(WORD_AW), .ADDR_W(ADDR_W)) dec_i (
    .addr(host_addr), .mem_hit(mem_hit), .mem_idx(mem_idx),
    .word(hword), .reg_hit(reg_hit), .reg_idx(reg_idx));

  assign e_read_req = host_rd_en && mem_hit && (mem_idx == MEM_E);

  pkha_ctrl #(.DATA_W(DATA_W), .ROUTINE_W(ROUTINE_W)) ctrl_i (
    .clk(clk), .rst(rst), .wr_en(host_wr_en), .rd_en(host_rd_en),
    .reg_hit(reg_hit), .reg_idx(reg_idx), .wdata(host_wdata[ROUTINE_W-1:0]),
    .e_read_req(e_read_req), .eng_err(eng_err), .routine(eng_routine),
    .start(eng_start), .halt(eng_halt), .irq(err_irq), .reg_rdata(reg_rdata));

  assign ec_mode  = eng_routine[ROUTINE_W-1];
  assign erd_addr = seg_map(eng_rd_mem, eng_rd_seg, eng_rd_word, ec_mode);
  assign ewr_addr = seg_map(MEM_B, eng_wr_seg, eng_wr_word, ec_mode);

  for (genvar g = 0; g < NUM_MEMS; g++) begin : g_mem
    localparam logic [MEM_IDX_W-1:0] ID = MEM_IDX_W'(g);
    localparam bit IS_RES = (ID == MEM_B);
    logic h_sel, e_rsel, e_w;
    assign h_sel  = mem_hit && (mem_idx == ID);
    assign e_rsel = eng_rd_en && (eng_rd_mem == ID);
    assign e_w    = IS_RES && eng_wr_en;
    pkha_opmem #(.DATA_W(DATA_W), .DEPTH(MEM_WORDS), .ENG_WR(IS_RES)) mem_i (
      .clk(clk),
      .h_we(host_wr_en && h_sel),
      .h_re(host_rd_en && h_sel && ID != MEM_E),
      .h_addr(hword), .h_wdata(host_wdata), .h_rdata(hrd[g]),
      .e_re(e_rsel), .e_we(e_w),
      .e_addr(e_w ? ewr_addr : erd_addr),
      .e_wdata(eng_wr_data), .e_rdata(erd[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      src_mem_q   <= 1'b0;
      src_reg_q   <= 1'b0;
      hsel_q      <= '0;
      esel_q      <= '0;
    end else begin
      host_rvalid <= host_rd_en;
      src_mem_q   <= host_rd_en && mem_hit && (mem_idx != MEM_E);
      src_reg_q   <= host_rd_en && reg_hit;
      if (host_rd_en) hsel_q <= mem_idx;
      if (eng_rd_en)  esel_q <= eng_rd_mem;
    end
  end

  assign host_rdata  = src_mem_q ? hrd[hsel_q] : (src_reg_q ? reg_rdata : '0);
  assign eng_rd_data = erd[esel_q];

  assert_rd_valid_R1: assert property (@(posedge clk) disable iff (rst)
    host_rd_en |=> host_rvalid);
  assert_e_read_blank_R2: assert property (@(posedge clk) disable iff (rst)
    e_read_req |=> (host_rvalid && host_rdata == '0));
  assert_halt_irq_agree_R5: assert property (@(posedge clk) disable iff (rst)
    eng_halt == err_irq);
endmodule

// File: tb/pkha_top_tb_top.sv
`timescale 1ns/1ps
module pkha_top_tb_top;
  logic        clk = 1'b0, rst = 1'b1;
  logic        host_wr_en = 0, host_rd_en = 0;
  logic [8:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_rvalid, eng_start, eng_halt, err_irq;
  logic [31:0] host_rdata, eng_rd_data;
  logic [4:0]  eng_routine;
  logic        eng_err = 0, eng_rd_en = 0, eng_wr_en = 0;
  logic [1:0]  eng_rd_mem = '0, eng_rd_seg = '0, eng_wr_seg = '0;
  logic [5:0]  eng_rd_word = '0, eng_wr_word = '0;
  logic [31:0] eng_wr_data = '0;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] mdl [4][64];

  always #2 clk = ~clk;

  pkha_top dut_i (.*);

  function automatic logic [8:0] maddr(input int m, input int w);
    return {1'b0, 2'(m), 6'(w)};
  endfunction
  function automatic logic [8:0] raddr(input int r);
    return {1'b1, 5'd0, 3'(r)};
  endfunction
  function automatic int ec_word(input int m, input int s, input int w, input bit ec);
    if (ec && m != 2) return s * 16 + (w % 16);
    return w;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic hwr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); host_wr_en = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr_en = 0;
  endtask
  task automatic hrd(input logic [8:0] a, output logic [31:0] d, output logic v);
    @(negedge clk); host_rd_en = 1; host_addr = a;
    @(negedge clk); host_rd_en = 0; d = host_rdata; v = host_rvalid;
  endtask
  task automatic erd(input int m, input int s, input int w, output logic [31:0] d);
    @(negedge clk); eng_rd_en = 1; eng_rd_mem = 2'(m); eng_rd_seg = 2'(s); eng_rd_word = 6'(w);
    @(negedge clk); eng_rd_en = 0; d = eng_rd_data;
  endtask
  task automatic ewr(input int s, input int w, input logic [31:0] d);
    @(negedge clk); eng_wr_en = 1; eng_wr_seg = 2'(s); eng_wr_word = 6'(w); eng_wr_data = d;
    @(negedge clk); eng_wr_en = 0;
  endtask
  task automatic epulse();
    @(negedge clk); eng_err = 1;
    @(negedge clk); eng_err = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, x;
    logic v;
    int m, w, s;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    // R12 reset state
    @(negedge clk);
    chk(!err_irq && !eng_halt && !eng_start, "R12 outputs after reset", {err_irq, eng_halt, eng_start}, 0);
    hrd(raddr(1), d, v); chk(d == 0, "R12 status reset", d, 0);
    hrd(raddr(2), d, v); chk(d == 0, "R12 mask reset", d, 0);
    hrd(raddr(0), d, v); chk(d == 0, "R12 routine reset", d, 0);

    // R1 random fill and readback of A, B, N
    for (int mm = 0; mm < 4; mm++)
      for (int ww = 0; ww < 64; ww++) begin
        mdl[mm][ww] = $urandom;
        hwr(maddr(mm, ww), mdl[mm][ww]);
      end
    for (int i = 0; i < 40; i++) begin
      m = $urandom_range(0, 2); if (m == 2) m = 3;
      w = $urandom_range(0, 63);
      hrd(maddr(m, w), d, v);
      chk(v && d == mdl[m][w], "R1 host readback", d, mdl[m][w]);
    end
    // R1 word 0 is the most significant word, seen identically by engine
    erd(0, 0, 0, d); chk(d == mdl[0][0], "R1 word0 ordering", d, mdl[0][0]);

    // R2/R4/R5 unmasked read of E
    hrd(maddr(2, 5), d, v);
    chk(v && d == 0, "R2 E read data zero", d, 0);
    chk(err_irq && eng_halt, "R4 irq and halt on address error", {err_irq, eng_halt}, 2'b11);
    hrd(raddr(1), d, v); chk(d == 32'h1, "R2 address error status bit", d, 1);
    repeat (5) @(negedge clk);
    chk(err_irq, "R5 irq held while idle", err_irq, 1);
    // R7 start while halted
    hwr(raddr(4), $urandom); chk(!eng_start, "R7 start ignored while halted", eng_start, 0);
    @(negedge clk); chk(!eng_start, "R7 no late start", eng_start, 0);
    // R8 clear with bit0 low, then high
    hwr(raddr(3), 32'hFFFF_FFFE); hrd(raddr(1), d, v);
    chk(d == 1 && err_irq, "R8 clear with bit0 low ignored", d, 1);
    hwr(raddr(3), 32'h1); hrd(raddr(1), d, v);
    chk(d == 0 && !err_irq && !eng_halt, "R8 clear empties status", d, 0);

    // R3 masked address error
    hwr(raddr(2), 32'h1);
    hrd(raddr(2), d, v); chk(d == 1, "R3 mask readback", d, 1);
    hrd(maddr(2, 9), d, v); chk(d == 0, "R3 masked E read still zero", d, 0);
    chk(!err_irq && !eng_halt, "R3 masked error silent", {err_irq, eng_halt}, 0);
    hrd(raddr(1), d, v); chk(d == 0, "R3 masked status unchanged", d, 0);

    // R9 engine error unmasked, then masked
    epulse();
    chk(err_irq && eng_halt, "R9 engine error raises irq", {err_irq, eng_halt}, 2'b11);
    hrd(raddr(1), d, v); chk(d == 2, "R9 engine status bit", d, 2);
    hwr(raddr(3), 1);
    hwr(raddr(2), 3);
    epulse();
    hrd(raddr(1), d, v); chk(d == 0 && !err_irq, "R9 masked engine error", d, 0);
    hwr(raddr(2), 0);

    // R6 start pulse and routine
    hwr(raddr(0), 32'hFFFF_FF05);
    hrd(raddr(0), d, v); chk(d == 5, "R6 routine readback", d, 5);
    hwr(raddr(4), 32'hDEAD_BEEF);
    chk(eng_start && eng_routine == 5, "R6 start pulse with routine", {eng_start, eng_routine}, {1'b1, 5'd5});
    @(negedge clk); chk(!eng_start, "R6 start lasts one cycle", eng_start, 0);
    hwr(raddr(4), 0); chk(eng_start, "R6 start with zero data", eng_start, 1);

    // R10 engine reads, linear then segmented
    for (int i = 0; i < 8; i++) begin
      m = $urandom_range(0, 3); s = $urandom_range(0, 3); w = $urandom_range(0, 63);
      erd(m, s, w, d); x = mdl[m][ec_word(m, s, w, 0)];
      chk(d == x, "R10 linear engine read", d, x);
    end
    hwr(raddr(0), 32'h11);
    for (int i = 0; i < 12; i++) begin
      m = $urandom_range(0, 3); s = $urandom_range(0, 3); w = $urandom_range(0, 63);
      erd(m, s, w, d); x = mdl[m][ec_word(m, s, w, 1)];
      chk(d == x, "R10 segmented engine read", d, x);
    end
    erd(2, 3, 7, d); chk(d == mdl[2][7], "R10 E never segmented", d, mdl[2][7]);

    // R11 engine writes into B
    ewr(2, 35, 32'hA5A5_0001); mdl[1][35] = 32'hA5A5_0001;
    hrd(maddr(1, 35), d, v); chk(d == 32'hA5A5_0001, "R11 segmented result write", d, 32'hA5A5_0001);
    ewr(1, 3, 32'h0BAD_F00D);
    hrd(maddr(1, 19), d, v); chk(d == 32'h0BAD_F00D, "R11 segment remap of word", d, 32'h0BAD_F00D);
    hrd(maddr(0, 19), d, v); chk(d == mdl[0][19], "R11 A untouched by result write", d, mdl[0][19]);
    hwr(raddr(0), 32'h02);
    ewr(1, 44, 32'h1234_5678);
    hrd(maddr(1, 44), d, v); chk(d == 32'h1234_5678, "R11 linear result write", d, 32'h1234_5678);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule